// File: doc/BRIEF.md
# Ring-Token Depth Chaining Controller

This controller sits beside one small FIFO core and lets several identical devices be joined into one deeper queue. Two ownership tokens travel around a closed ring of devices: a write token and a read token. Only the holder of the write token may load its core. Only the holder of the read token may unload its core and drive the shared output bus. When a device fills its last storage slot, it passes the write token on with a one-clock pulse on its expansion output. It passes the read token the same way when it reads its last slot. Each expansion output is wired to the expansion input of the next device, and the last device feeds the first. A strap input chooses which device starts with both tokens after reset.

The controller has a mode input. In chained mode the half-full pin carries the write expansion pulse, and retransmit requests are refused. In solo mode the tokens play no part. Enables pass straight through, the pointers wrap with no pulses, the half-full pin shows the core's own half-full status, and a retransmit request rewinds the read pointer to slot 0. The controller keeps the local write and read slot addresses and gives the core gated enables, so the core itself needs no pointer logic.

Top module: `cascade_exp_ctl`

## Requirements
- R1: While reset is held, and on the first cycle after it, a device with `first_load_n` = 0 holds both tokens. A device with `first_load_n` = 1 holds neither. Both slot addresses are 0 and both expansion outputs are 0.
- R2: In chained mode `core_we` = `wr_en` AND (write token held). A device without the write token ignores `wr_en`.
- R3: In chained mode, each accepted write advances `core_waddr` by 1. A write at slot DEPTH-1 wraps it to 0, drops the write token on that edge, and raises `wxo_hf` for exactly the next cycle.
- R4: A device that samples `wxi` = 1 on a write clock edge holds the write token from that edge on, and its next write goes to the slot after its last one (slot 0 after a wrap).
- R5: The read side mirrors R2 to R4 on `rclk`, using `rd_en`, `core_re`, `core_raddr`, `rxi` and `rxo`.
- R6: `q_drive` = `oe` AND (read token held, or solo mode). A device without the read token leaves the bus undriven whatever the state of `oe`.
- R7: In the cycle a device's expansion pulse is high, no device in the ring accepts an access of that kind. The handover costs one idle slot: with enables held high, each device takes DEPTH accesses and then one cycle is lost.
- R8: When `cascade_en` = 1, `wxo_hf` shows the write expansion pulse and ignores `local_hf`. When `cascade_en` = 0, `wxo_hf` equals `local_hf`.
- R9: When `cascade_en` = 0, the tokens and the strap have no effect. `core_we` follows `wr_en` and `core_re` follows `rd_en`, both addresses wrap modulo DEPTH, and `rxo` stays 0.
- R10: When `cascade_en` = 0, `rt_req` sets `core_rt` and returns `core_raddr` to 0 on the next `rclk` edge, taking priority over a read in the same cycle. When `cascade_en` = 1, `core_rt` stays 0 and `rt_req` does not alter `core_raddr`.
- R11: The token passed on by the last device in the ring returns to the strapped first device, which then starts again at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, sampled on both clocks |
| cascade_en | input | 1 | 1 = chained ring mode, 0 = solo mode |
| first_load_n | input | 1 | Strap; 0 marks the device that starts with both tokens |
| wr_en | input | 1 | Write request, active high |
| rd_en | input | 1 | Read request, active high |
| oe | input | 1 | Shared output enable, active high |
| rt_req | input | 1 | Retransmit request |
| local_hf | input | 1 | Half-full status from the local core |
| wxi | input | 1 | Write expansion input from the previous device |
| rxi | input | 1 | Read expansion input from the previous device |
| wxo_hf | output | 1 | Write expansion pulse (chained) or half-full status (solo) |
| rxo | output | 1 | Read expansion pulse |
| core_we | output | 1 | Gated write strobe to the core |
| core_waddr | output | AW | Core slot for the next write |
| core_re | output | 1 | Gated read strobe to the core |
| core_raddr | output | AW | Core slot for the next read |
| q_drive | output | 1 | Output-bus drive enable |
| core_rt | output | 1 | Retransmit strobe passed to the core |

## Verification
The strobes, the slot addresses, `q_drive` and `core_rt` are combinational from the current enables and the registered token state, so the bench checks them a moment after it drives the enables in the same low clock phase. An expansion pulse appears one edge after the access to the last slot. The next device's ownership appears one edge after that. With enables held high in a three-device ring of depth 4, each side repeats every 5 cycles per device and every 15 cycles around the ring, so the bench computes the owner, the slot and the pulse for cycle i from i mod 5 and (i div 5) mod 3. A rewind requested in solo mode shows as slot 0 on the cycle after the request.

// File: rtl/cascade_exp_pkg.sv
package cascade_exp_pkg;

    typedef enum logic {
        MODE_SOLO  = 1'b0,
        MODE_CHAIN = 1'b1
    } exp_mode_e;

    // Per-side ownership state
    typedef struct packed {
        logic own;    // this device holds the token
        logic pulse;  // expansion pulse being issued this cycle
    } token_t;

    function automatic logic at_last(input int slot, input int depth);
        return slot == depth - 1;
    endfunction

endpackage

// File: rtl/cascade_exp_side.sv
module cascade_exp_side
    import cascade_exp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  exp_mode_e                     mode,
    input  logic                          strap_first,
    input  logic                          req,
    input  logic                          xin,
    input  logic                          restart,
    output logic                          acc,
    output logic [$clog2(DEPTH)-1:0]      ptr,
    output logic                          xout,
    output logic                          own
);
    localparam int AW = $clog2(DEPTH);

    token_t         st;
    logic [AW-1:0]  ptr_q;
    logic           solo;
    logic           last;

    assign solo = (mode == MODE_SOLO);
    assign acc  = req & (solo | st.own);
    assign last = at_last(int'(ptr_q), DEPTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            st.own   <= strap_first;
            st.pulse <= 1'b0;
            ptr_q    <= '0;
        end else begin
            st.pulse <= 1'b0;
            if (restart)
                ptr_q <= '0;
            else if (acc)
                ptr_q <= last ? '0 : ptr_q + 1'b1;
            if (acc && !solo && last) begin
                st.own   <= 1'b0;
                st.pulse <= 1'b1;
            end
            if (!solo && xin)
                st.own <= 1'b1;
        end
    end

    assign ptr  = ptr_q;
    assign xout = st.pulse;
    assign own  = st.own;
endmodule

// File: rtl/cascade_exp_pins.sv
module cascade_exp_pins
    import cascade_exp_pkg::*;
(
    input  exp_mode_e mode,
    input  logic      local_hf,
    input  logic      w_pulse,
    input  logic      r_own,
    input  logic      oe,
    input  logic      rt_req,
    output logic      wxo_hf,
    output logic      q_drive,
    output logic      core_rt
);
    always_comb begin
        if (mode == MODE_CHAIN) begin
            wxo_hf  = w_pulse;
            q_drive = oe & r_own;
            core_rt = 1'b0;
        end else begin
            wxo_hf  = local_hf;
            q_drive = oe;
            core_rt = rt_req;
        end
    end
endmodule

// File: rtl/cascade_exp_ctl.sv
module cascade_exp_ctl
    import cascade_exp_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst,
    input  logic          cascade_en,
    input  logic          first_load_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          oe,
    input  logic          rt_req,
    input  logic          local_hf,
    input  logic          wxi,
    input  logic          rxi,
    output logic          wxo_hf,
    output logic          rxo,
    output logic          core_we,
    output logic [AW-1:0] core_waddr,
    output logic          core_re,
    output logic [AW-1:0] core_raddr,
    output logic          q_drive,
    output logic          core_rt
);
    exp_mode_e mode;
    logic      w_pulse;
    logic      w_own;
    logic      r_own;
    logic      rt_ok;

    assign mode = cascade_en ? MODE_CHAIN : MODE_SOLO;

    cascade_exp_side #(.DEPTH(DEPTH)) u_wside (
        .clk         (wclk),
        .rst         (rst),
        .mode        (mode),
        .strap_first (~first_load_n),
        .req         (wr_en),
        .xin         (wxi),
        .restart     (1'b0),
        .acc         (core_we),
        .ptr         (core_waddr),
        .xout        (w_pulse),
        .own         (w_own)
    );

    cascade_exp_side #(.DEPTH(DEPTH)) u_rside (
        .clk         (rclk),
        .rst         (rst),
        .mode        (mode),
        .strap_first (~first_load_n),
        .req         (rd_en),
        .xin         (rxi),
        .restart     (rt_ok),
        .acc         (core_re),
        .ptr         (core_raddr),
        .xout        (rxo),
        .own         (r_own)
    );

    cascade_exp_pins u_pins (
        .mode     (mode),
        .local_hf (local_hf),
        .w_pulse  (w_pulse),
        .r_own    (r_own),
        .oe       (oe),
        .rt_req   (rt_req),
        .wxo_hf   (wxo_hf),
        .q_drive  (q_drive),
        .core_rt  (rt_ok)
    );

    assign core_rt = rt_ok;

    logic unused_w_own;
    assign unused_w_own = w_own;
endmodule

// File: rtl/cascade_exp_chk.sv
module cascade_exp_chk #(
    parameter int DEPTH = 4,
    parameter int AW    = $clog2(DEPTH)
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst,
    input logic          cascade_en,
    input logic          wr_en,
    input logic          rd_en,
    input logic          oe,
    input logic          wxo_hf,
    input logic          rxo,
    input logic          core_we,
    input logic [AW-1:0] core_waddr,
    input logic          core_re,
    input logic [AW-1:0] core_raddr,
    input logic          q_drive,
    input logic          core_rt
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    a_r2_we_needs_req: assert property (@(posedge wclk) disable iff (rst)
        core_we |-> wr_en);

    a_r3_pulse_after_last: assert property (@(posedge wclk) disable iff (rst)
        (cascade_en && core_we && core_waddr == LAST) |=> (wxo_hf || !cascade_en));

    a_r3_pulse_one_cycle: assert property (@(posedge wclk) disable iff (rst)
        (cascade_en && wxo_hf) |=> !(cascade_en && wxo_hf));

    a_r3_waddr_step: assert property (@(posedge wclk) disable iff (rst)
        (core_we && core_waddr != LAST) |=> core_waddr == $past(core_waddr) + 1'b1);

    a_r7_no_write_in_gap: assert property (@(posedge wclk) disable iff (rst)
        (cascade_en && wxo_hf) |-> !core_we);

    a_r5_re_needs_req: assert property (@(posedge rclk) disable iff (rst)
        core_re |-> rd_en);

    a_r5_pulse_after_last: assert property (@(posedge rclk) disable iff (rst)
        (cascade_en && core_re && core_raddr == LAST) |=> (rxo || !cascade_en));

    a_r7_no_read_in_gap: assert property (@(posedge rclk) disable iff (rst)
        (cascade_en && rxo) |-> !core_re);

    a_r6_drive_needs_oe: assert property (@(posedge rclk) disable iff (rst)
        q_drive |-> oe);

    a_r10_no_rt_chained: assert property (@(posedge rclk) disable iff (rst)
        cascade_en |-> !core_rt);
endmodule

bind cascade_exp_ctl cascade_exp_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .wclk       (wclk),
    .rclk       (rclk),
    .rst        (rst),
    .cascade_en (cascade_en),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .oe         (oe),
    .wxo_hf     (wxo_hf),
    .rxo        (rxo),
    .core_we    (core_we),
    .core_waddr (core_waddr),
    .core_re    (core_re),
    .core_raddr (core_raddr),
    .q_drive    (q_drive),
    .core_rt    (core_rt)
);

// File: tb/sim_cascade_exp_ctl.sv
`timescale 1ns/1ps
module sim_cascade_exp_ctl;
    localparam int DEPTH = 4;
    localparam int AW    = 2;
    localparam int NDEV  = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, wr, rd, oe, rt;
    logic s_wr, s_rd, s_rt, s_hf;
    int   ncmp = 0;
    int   nfail = 0;

    logic          we   [NDEV];
    logic          re   [NDEV];
    logic [AW-1:0] wa   [NDEV];
    logic [AW-1:0] ra   [NDEV];
    logic          wx   [NDEV];
    logic          rx   [NDEV];
    logic          qd   [NDEV];
    logic          crt  [NDEV];

    logic          we3, re3, wx3, rx3, qd3, rt3;
    logic [AW-1:0] wa3, ra3;

    cascade_exp_ctl #(.DEPTH(DEPTH)) u0 (
        .wclk(clk), .rclk(clk), .rst(rst), .cascade_en(1'b1), .first_load_n(1'b0),
        .wr_en(wr), .rd_en(rd), .oe(oe), .rt_req(rt), .local_hf(1'b1),
        .wxi(wx[2]), .rxi(rx[2]), .wxo_hf(wx[0]), .rxo(rx[0]),
        .core_we(we[0]), .core_waddr(wa[0]), .core_re(re[0]), .core_raddr(ra[0]),
        .q_drive(qd[0]), .core_rt(crt[0]));

    cascade_exp_ctl #(.DEPTH(DEPTH)) u1 (
        .wclk(clk), .rclk(clk), .rst(rst), .cascade_en(1'b1), .first_load_n(1'b1),
        .wr_en(wr), .rd_en(rd), .oe(oe), .rt_req(rt), .local_hf(1'b1),
        .wxi(wx[0]), .rxi(rx[0]), .wxo_hf(wx[1]), .rxo(rx[1]),
        .core_we(we[1]), .core_waddr(wa[1]), .core_re(re[1]), .core_raddr(ra[1]),
        .q_drive(qd[1]), .core_rt(crt[1]));

    cascade_exp_ctl #(.DEPTH(DEPTH)) u2 (
        .wclk(clk), .rclk(clk), .rst(rst), .cascade_en(1'b1), .first_load_n(1'b1),
        .wr_en(wr), .rd_en(rd), .oe(oe), .rt_req(rt), .local_hf(1'b1),
        .wxi(wx[1]), .rxi(rx[1]), .wxo_hf(wx[2]), .rxo(rx[2]),
        .core_we(we[2]), .core_waddr(wa[2]), .core_re(re[2]), .core_raddr(ra[2]),
        .q_drive(qd[2]), .core_rt(crt[2]));

    // Solo-mode device, strapped as a non-first device on purpose
    cascade_exp_ctl #(.DEPTH(DEPTH)) u3 (
        .wclk(clk), .rclk(clk), .rst(rst), .cascade_en(1'b0), .first_load_n(1'b1),
        .wr_en(s_wr), .rd_en(s_rd), .oe(1'b1), .rt_req(s_rt), .local_hf(s_hf),
        .wxi(1'b0), .rxi(1'b0), .wxo_hf(wx3), .rxo(rx3),
        .core_we(we3), .core_waddr(wa3), .core_re(re3), .core_raddr(ra3),
        .q_drive(qd3), .core_rt(rt3));

    task automatic chk(input string tag, input int act, input int exp);
        ncmp++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
    endtask

    initial begin
        #1_000_000;
        nfail++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
        summary();
        $finish;
    end

    initial begin
        int slot, dev, exp_ra;
        rst = 1'b1; wr = 1'b0; rd = 1'b0; oe = 1'b0; rt = 1'b0;
        s_wr = 1'b0; s_rd = 1'b0; s_rt = 1'b0; s_hf = 1'b0;
        repeat (3) @(negedge clk);

        // R1: strap decides token ownership at reset
        wr = 1'b1; rd = 1'b1; oe = 1'b1;
        #1;
        for (int d = 0; d < NDEV; d++) begin
            chk("R1 write token", int'(we[d]), (d == 0) ? 1 : 0);
            chk("R1 read token", int'(re[d]), (d == 0) ? 1 : 0);
            chk("R1 drive", int'(qd[d]), (d == 0) ? 1 : 0);
            chk("R1 waddr", int'(wa[d]), 0);
            chk("R1 raddr", int'(ra[d]), 0);
            chk("R1 wxo", int'(wx[d]), 0);
            chk("R1 rxo", int'(rx[d]), 0);
        end
        rd = 1'b0;
        rst = 1'b0;
        #1;

        // Phase A: continuous writes around the ring (R2 R3 R4 R7 R8 R11)
        for (int i = 0; i < 30; i++) begin
            if (i > 0) @(negedge clk);
            wr = 1'b1; rd = 1'b0; oe = 1'b1;
            #1;
            slot = i % 5;
            dev  = (i / 5) % NDEV;
            for (int d = 0; d < NDEV; d++) begin
                if (slot == 4)
                    chk("R7 write gap", int'(we[d]), 0);
                else if (i >= 15)
                    chk("R11 write owner after wrap", int'(we[d]), (d == dev) ? 1 : 0);
                else
                    chk("R2 R4 write owner", int'(we[d]), (d == dev) ? 1 : 0);
                if (slot != 4 && d == dev)
                    chk("R3 write slot", int'(wa[d]), slot);
                chk("R3 R8 wxo pulse", int'(wx[d]), (slot == 4 && d == dev) ? 1 : 0);
                chk("R6 drive holder", int'(qd[d]), (d == 0) ? 1 : 0);
                chk("R5 no read", int'(re[d]), 0);
            end
        end

        // Phase B: continuous reads, oe varied, retransmit refused (R5 R6 R7 R10)
        for (int j = 0; j < 30; j++) begin
            @(negedge clk);
            wr = 1'b0; rd = 1'b1; rt = 1'b1; oe = (j % 3 != 1);
            #1;
            slot = j % 5;
            dev  = (j / 5) % NDEV;
            for (int d = 0; d < NDEV; d++) begin
                if (slot == 4)
                    chk("R7 read gap", int'(re[d]), 0);
                else
                    chk("R5 read owner", int'(re[d]), (d == dev) ? 1 : 0);
                if (slot != 4 && d == dev)
                    chk("R5 R10 read slot", int'(ra[d]), slot);
                chk("R5 rxo pulse", int'(rx[d]), (slot == 4 && d == dev) ? 1 : 0);
                chk("R6 drive", int'(qd[d]), (oe && slot != 4 && d == dev) ? 1 : 0);
                chk("R10 rt refused", int'(crt[d]), 0);
                chk("R2 no write", int'(we[d]), 0);
            end
        end
        @(negedge clk);
        rd = 1'b0; rt = 1'b0;

        // Phase C: solo device (R8 R9 R10)
        for (int k = 0; k < 12; k++) begin
            if (k > 0) @(negedge clk);
            s_wr = 1'b1; s_rd = 1'b1; s_hf = k[0]; s_rt = (k == 6);
            #1;
            exp_ra = (k <= 6) ? (k % 4) : ((k - 7) % 4);
            chk("R9 solo write", int'(we3), 1);
            chk("R9 solo read", int'(re3), 1);
            chk("R9 solo waddr", int'(wa3), k % 4);
            chk("R10 solo raddr", int'(ra3), exp_ra);
            chk("R8 solo hf", int'(wx3), int'(s_hf));
            chk("R9 solo rxo", int'(rx3), 0);
            chk("R9 solo drive", int'(qd3), 1);
            chk("R10 solo rt", int'(rt3), (k == 6) ? 1 : 0);
        end

        // R9: solo enables off -> strobes off
        @(negedge clk);
        s_wr = 1'b0; s_rd = 1'b0; s_rt = 1'b0;
        #1;
        chk("R9 solo idle write", int'(we3), 0);
        chk("R9 solo idle read", int'(re3), 0);

        summary();
        $finish;
    end
endmodule